// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Code Register Bank

This block holds the digital codes for an eight-channel digital-to-analog converter. Each channel has two ranks. A host write port fills the front rank, which is the staging register. The back rank drives the channel's output code. Data moves from the front rank to the back rank only when the active-low load strobe `load_n` allows it. This lets software stage new values on several channels and then change all outputs in the same clock cycle.

An active-low clear input `clear_n` acts on its falling edge. It forces both ranks of every channel to a selectable clear code: zero scale, midscale or full scale. While `clear_n` stays low, the load strobe is ignored.

Both strobes arrive asynchronously and pass through synchronisers inside the block. The output resolution is a parameter. A 12-bit build keeps its codes left-justified in the 16-bit word and forces the low four bits to zero.

Top module: `dac_dbuf_bank`

## Requirements
- R1: After reset, every channel output is 0x0000 and the clear setting selects zero scale.
- R2: A host write (`wr_en` high, channel `wr_ch`, data `wr_data`) updates only that channel's staging register. It sets that channel's new-data flag. While `load_n` stays high, no output changes.
- R3: A low pulse on `load_n` that is shorter than `LOW_HOLD` cycles moves every channel holding new data to its output on the pulse's rising edge. All affected outputs change in the same cycle, three clock edges after `load_n` rises. Channels without new data keep their output.
- R4: Once `load_n` has been low for `LOW_HOLD` synchronised cycles, the block enters through mode. In through mode, a write reaches its output one clock after it reaches the staging register.
- R5: A falling edge of `clear_n` loads both ranks of every channel with the clear code and drops all new-data flags. A later load pulse with no write in between leaves the outputs at the clear code.
- R6: While `clear_n` is low, load pulses and through mode move nothing. Writes made during that time are still staged and move out on the first load pulse after `clear_n` returns high.
- R7: The 2-bit clear setting `clr_sel` is encoded as follows: 00 is zero scale (0x0000), 01 is midscale (0x8000), and 10 or 11 is full scale (0xFFFF, or 0xFFF0 in a 12-bit build).
- R8: If a host write lands in the same cycle as the clear edge takes effect, the clear wins. The written data is lost and no new-data flag remains set.
- R9: With `RES_BITS` = 12, the low four bits of every written code are forced to zero.
- R10: Writing the clear setting (`clr_sel_we` high) changes no output and no staging register. The new setting takes effect only at the next clear edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Host write strobe for a staging register |
| wr_ch | input | CH_W (3) | Channel index of the host write |
| wr_data | input | DATA_W (16) | Code written to the staging register |
| clr_sel_we | input | 1 | Write strobe for the clear setting |
| clr_sel | input | 2 | New clear setting (00 zero, 01 mid, 1x full) |
| load_n | input | 1 | Asynchronous active-low load strobe |
| clear_n | input | 1 | Asynchronous active-low clear, falling-edge acting |
| dac_out | output | NUM_CH*DATA_W (128) | Output codes, channel k in bits [k*16 +: 16] |

## Verification
The assertions assume that `load_n` and `clear_n` reach the core only through the internal synchronisers. They also assume that a clear edge and a load edge never take effect in the same cycle. The stimulus holds each strobe level for at least three clocks, so that the synchronisers always present clean single-cycle edges. It never lets a clear edge and a load release overlap.

Only one collision is provoked on purpose. In that case the write strobe is timed to the exact cycle in which the synchronised clear edge acts, to exercise the clear-wins rule.

// File: rtl/dac_dbuf_pkg.sv
`timescale 1ns/1ps
package dac_dbuf_pkg;
   typedef enum logic [1:0] {
      CLR_ZERO  = 2'b00,
      CLR_MID   = 2'b01,
      CLR_FULL  = 2'b10,
      CLR_FULL2 = 2'b11
   } clr_sel_e;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;
endpackage

// File: rtl/dac_sync_edge.sv
`timescale 1ns/1ps
module dac_sync_edge
   import dac_dbuf_pkg::*;
#(
   parameter int         STAGES  = 2,
   parameter logic       RST_VAL = 1'b1,
   parameter edge_kind_e EDGE    = EDGE_RISE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level_o,
   output logic edge_o
);
   localparam int MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_sync_edge: STAGES must be at least 2");
   end

   logic [MSB:0] chain_q;
   logic         last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
         last_q  <= RST_VAL;
      end else begin
         chain_q <= {chain_q[MSB-1:0], async_in};
         last_q  <= chain_q[MSB];
      end
   end

   assign level_o = chain_q[MSB];

   if (EDGE == EDGE_RISE) begin : g_rise
      assign edge_o = chain_q[MSB] & ~last_q;
   end else begin : g_fall
      assign edge_o = ~chain_q[MSB] & last_q;
   end

   // R3
   edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o);
endmodule

// File: rtl/dac_clr_code.sv
`timescale 1ns/1ps
module dac_clr_code
   import dac_dbuf_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RES_BITS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_we,
   input  logic [1:0]        sel_in,
   output logic [DATA_W-1:0] code_o
);
   localparam int              PAD       = DATA_W - RES_BITS;
   localparam logic [DATA_W-1:0] LSB_MASK  = (DATA_W'(1) << PAD) - DATA_W'(1);
   localparam logic [DATA_W-1:0] FULL_CODE = ~LSB_MASK;
   localparam logic [DATA_W-1:0] MID_CODE  = DATA_W'(1) << (DATA_W - 1);

   clr_sel_e sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= CLR_ZERO;
      else if (sel_we) sel_q <= clr_sel_e'(sel_in);
   end

   always_comb begin
      unique case (sel_q)
         CLR_ZERO:  code_o = '0;
         CLR_MID:   code_o = MID_CODE;
         default:   code_o = FULL_CODE;
      endcase
   end

   // R10
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_we |=> $stable(sel_q));
endmodule

// File: rtl/dac_channel.sv
`timescale 1ns/1ps
module dac_channel #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              xfer_en,
   input  logic              clr_pulse,
   input  logic [DATA_W-1:0] clr_code,
   output logic [DATA_W-1:0] dac_o
);
   logic [DATA_W-1:0] stage_q;
   logic [DATA_W-1:0] dac_q;
   logic              fresh_q;
   logic              move;

   assign move = fresh_q & xfer_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         dac_q   <= '0;
         fresh_q <= 1'b0;
      end else if (clr_pulse) begin
         stage_q <= clr_code;
         dac_q   <= clr_code;
         fresh_q <= 1'b0;
      end else begin
         if (move) dac_q <= stage_q;
         if (wr_hit) begin
            stage_q <= wr_data;
            fresh_q <= 1'b1;
         end else if (move) begin
            fresh_q <= 1'b0;
         end
      end
   end

   assign dac_o = dac_q;

   // R2
   write_marks_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit && !clr_pulse |=> fresh_q);
   // R3
   move_copies_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      move && !clr_pulse |=> dac_q == $past(stage_q));
   // R5
   clear_both_ranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> dac_q == stage_q && !fresh_q);
   // R6
   dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_en && !clr_pulse |=> $stable(dac_q));
   // R8
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse && wr_hit |=> !fresh_q);
endmodule

// File: rtl/dac_dbuf_bank.sv
`timescale 1ns/1ps
module dac_dbuf_bank
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH      = 8,
   parameter int DATA_W      = 16,
   parameter int RES_BITS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int LOW_HOLD    = 16,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [CH_W-1:0]          wr_ch,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     clr_sel_we,
   input  logic [1:0]               clr_sel,
   input  logic                     load_n,
   input  logic                     clear_n,
   output logic [NUM_CH*DATA_W-1:0] dac_out
);
   localparam int PAD    = DATA_W - RES_BITS;
   localparam int HOLD_W = $clog2(LOW_HOLD + 1);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("dac_dbuf_bank: NUM_CH must be at least 1");
   end
   if (RES_BITS < 1 || RES_BITS > DATA_W) begin : g_bad_res
      $error("dac_dbuf_bank: RES_BITS must lie in 1..DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_w
      $error("dac_dbuf_bank: DATA_W must be at least 2");
   end
   if (LOW_HOLD < 1) begin : g_bad_hold
      $error("dac_dbuf_bank: LOW_HOLD must be at least 1");
   end

   logic              ld_lvl, ld_rise;
   logic              cl_lvl, cl_fall;
   logic [DATA_W-1:0] clr_code;
   logic [DATA_W-1:0] wr_aligned;
   logic [HOLD_W-1:0] hold_cnt;
   logic              tied_low;
   logic              xfer_en;

   dac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .EDGE(EDGE_RISE)) u_load_sync (
      .clk(clk), .rst_n(rst_n), .async_in(load_n), .level_o(ld_lvl), .edge_o(ld_rise)
   );

   dac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .EDGE(EDGE_FALL)) u_clear_sync (
      .clk(clk), .rst_n(rst_n), .async_in(clear_n), .level_o(cl_lvl), .edge_o(cl_fall)
   );

   dac_clr_code #(.DATA_W(DATA_W), .RES_BITS(RES_BITS)) u_clr_code (
      .clk(clk), .rst_n(rst_n), .sel_we(clr_sel_we), .sel_in(clr_sel), .code_o(clr_code)
   );

   if (PAD == 0) begin : g_full_res
      assign wr_aligned = wr_data;
   end else begin : g_part_res
      assign wr_aligned = {wr_data[DATA_W-1:PAD], {PAD{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hold_cnt <= '0;
      else if (ld_lvl)   hold_cnt <= '0;
      else if (!tied_low) hold_cnt <= hold_cnt + HOLD_W'(1);
   end

   assign tied_low = (hold_cnt == HOLD_W'(LOW_HOLD));
   assign xfer_en  = cl_lvl & (ld_rise | (tied_low & ~ld_lvl));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = wr_en && (wr_ch == CH_W'(i));
      dac_channel #(.DATA_W(DATA_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_data(wr_aligned),
         .xfer_en(xfer_en), .clr_pulse(cl_fall), .clr_code(clr_code),
         .dac_o(dac_out[i*DATA_W +: DATA_W])
      );
   end

   // R4
   through_mode_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tied_low && ld_lvl |=> !tied_low);
   // R6
   clear_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cl_lvl && !cl_fall |=> $stable(dac_out));
   // R2
   idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_lvl && !ld_rise && !cl_fall |=> $stable(dac_out));
endmodule

// File: tb/dac_dbuf_bank_tb.sv
`timescale 1ns/1ps
module dac_dbuf_bank_tb;
   localparam int NCH = 8;
   localparam int DW  = 16;

   typedef struct {
      int          sel;
      int          ch;
      logic [15:0] val;
      string       tag;
   } sb_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_ch = '0;
   logic [15:0] wr_data = '0;
   logic clr_sel_we = 1'b0;
   logic [1:0] clr_sel = '0;
   logic load_n = 1'b1;
   logic clear_n = 1'b1;
   logic [NCH*DW-1:0] out16, out12;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   sb_item_t sb_q[$];

   always #10 clk = ~clk;

   dac_dbuf_bank #(.RES_BITS(16)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
      .clr_sel_we(clr_sel_we), .clr_sel(clr_sel), .load_n(load_n), .clear_n(clear_n),
      .dac_out(out16));

   dac_dbuf_bank #(.RES_BITS(12)) u_dut12 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
      .clr_sel_we(clr_sel_we), .clr_sel(clr_sel), .load_n(load_n), .clear_n(clear_n),
      .dac_out(out12));

   // monitor: compares queued expectations away from the clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [15:0] act;
            it  = sb_q.pop_front();
            act = (it.sel == 0) ? out16[it.ch*DW +: DW] : out12[it.ch*DW +: DW];
            checks++;
            if (act !== it.val) begin
               errors++;
               $display("FAIL %s dut%0d ch%0d actual %h expected %h",
                        it.tag, it.sel == 0 ? 16 : 12, it.ch, act, it.val);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_ch(input int ch, input logic [15:0] v, input string tag);
      sb_item_t a, b;
      a = '{sel: 0, ch: ch, val: v, tag: tag};
      b = '{sel: 1, ch: ch, val: v & 16'hFFF0, tag: tag};
      sb_q.push_back(a);
      sb_q.push_back(b);
   endtask

   task automatic flush();
      wait (sb_q.size() == 0);
      tick(1);
   endtask

   task automatic host_write(input int ch, input logic [15:0] v);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_data = v;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic set_clr(input logic [1:0] s);
      clr_sel_we = 1'b1; clr_sel = s;
      tick(1);
      clr_sel_we = 1'b0;
   endtask

   task automatic load_pulse();
      load_n = 1'b0; tick(3);
      load_n = 1'b1; tick(5);
   endtask

   task automatic clear_cycle();
      clear_n = 1'b0; tick(5);
      clear_n = 1'b1; tick(4);
   endtask

   function automatic logic [15:0] pat(input int i);
      return 16'h1234 + 16'(i) * 16'h0F0F;
   endfunction

   initial begin
      logic [15:0] cur [NCH];
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R1: reset state
      for (int i = 0; i < NCH; i++) begin expect_ch(i, 16'h0000, "R1 reset"); cur[i] = 16'h0000; end
      flush();

      // R2: staged writes do not reach outputs
      for (int i = 0; i < NCH; i++) host_write(i, pat(i));
      tick(3);
      for (int i = 0; i < NCH; i++) expect_ch(i, 16'h0000, "R2 staged only");
      flush();

      // R3: short pulse, outputs change together after release
      load_n = 1'b0; tick(3);
      load_n = 1'b1; tick(1);
      expect_ch(0, 16'h0000, "R3 not before release");
      expect_ch(7, 16'h0000, "R3 not before release");
      flush();
      tick(3);
      for (int i = 0; i < NCH; i++) begin expect_ch(i, pat(i), "R3 load moves all"); cur[i] = pat(i); end
      flush();

      // R3: only fresh channel changes; R9 low bits masked in 12-bit build
      host_write(2, 16'hABCD);
      load_pulse();
      cur[2] = 16'hABCD;
      for (int i = 0; i < NCH; i++) expect_ch(i, cur[i], "R3 R9 partial load");
      flush();

      // R4: through mode after a long low level
      load_n = 1'b0; tick(30);
      host_write(5, 16'h5A5A);
      tick(1);
      expect_ch(5, 16'h5A5A, "R4 through mode");
      flush();
      host_write(6, 16'hC3C7);
      tick(2);
      expect_ch(6, 16'hC3C7, "R4 through mode second");
      flush();
      cur[5] = 16'h5A5A; cur[6] = 16'hC3C7;
      load_n = 1'b1; tick(5);

      // R10: setting write leaves outputs alone
      set_clr(2'b01);
      tick(3);
      for (int i = 0; i < NCH; i++) expect_ch(i, cur[i], "R10 setting write no effect");
      flush();

      // R5 R7: staged ch3 data is wiped by clear at midscale
      host_write(3, 16'h7777);
      clear_n = 1'b0; tick(5);
      for (int i = 0; i < NCH; i++) expect_ch(i, 16'h8000, "R5 R7 midscale clear");
      flush();

      // R6: load pulse while clear held low is ignored
      host_write(1, 16'h4321);
      load_pulse();
      expect_ch(1, 16'h8000, "R6 load blocked during clear");
      flush();
      clear_n = 1'b1; tick(4);
      load_pulse();
      expect_ch(1, 16'h4321, "R6 staged write moves after clear");
      expect_ch(3, 16'h8000, "R5 staging rank overwritten by clear");
      flush();

      // R8: write in the cycle the clear edge acts; R7 full scale
      set_clr(2'b10);
      clear_n = 1'b0; tick(2);
      wr_en = 1'b1; wr_ch = 3'd4; wr_data = 16'h1357;
      tick(1);
      wr_en = 1'b0;
      tick(3);
      clear_n = 1'b1; tick(4);
      load_pulse();
      expect_ch(4, 16'hFFFF, "R8 clear beats write");
      expect_ch(0, 16'hFFFF, "R7 full scale");
      flush();

      // R7: code 11 also full scale, then 00 zero scale
      set_clr(2'b11);
      host_write(0, 16'h0101);
      load_pulse();
      expect_ch(0, 16'h0101, "R7 pre clear");
      flush();
      clear_cycle();
      expect_ch(0, 16'hFFFF, "R7 code 11 full");
      flush();
      set_clr(2'b00);
      clear_cycle();
      for (int i = 0; i < NCH; i++) expect_ch(i, 16'h0000, "R7 code 00 zero");
      flush();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule